// File: doc/BRIEF.md
# Peripheral Control and Status Register Block

This block holds the software-visible registers of a small peripheral and is reached over an APB-style 32-bit register bus. It takes a bus address, subtracts a configurable block base, and picks one of five 32-bit registers. Every register is aligned to a 4-byte boundary, so one transfer covers exactly one register. The registers are a read/write control word, a read-only status word fed by the core, a read/write interrupt enable mask, a write-one-to-clear pending-event word and a read-only identification constant. Accesses that hit no register, or that are not word-aligned, are refused with an error response.

The core reports its condition on busy/done inputs and raises one-cycle event pulses, one wire per interrupt source. Each pulse latches a pending flag whether or not that source is enabled. The enabled pending flags are ORed into a single registered interrupt line. The bus has no wait states.

A small state machine follows the bus phases. It has three states: PH_IDLE (no select), PH_SETUP (select high, enable low) and PH_ACCESS (select and enable both high). The transitions are named as follows. Start is any state to PH_SETUP when select rises without enable. Advance is PH_SETUP to PH_ACCESS when enable rises. Back-to-back is PH_ACCESS to PH_SETUP when a new setup phase follows at once. Release is any state to PH_IDLE when select drops. A register is written only at the edge that ends an access phase which came straight after a setup phase.

Top module: `csr_periph_regs`

## Requirements
- R1: The registers are decoded at byte offsets from BASE_ADDR: control at 0x00, status at 0x04, interrupt enable at 0x08, pending at 0x0C and identification at 0x10.
- R2: After reset, the control, enable and pending registers read zero and the interrupt output is low.
- R3: Control is read/write. Bit 0 is the enable and drives ctrl_enable. Bits 2:1 are the mode and drive ctrl_mode. All other bits read zero.
- R4: Status reads core_busy in bit 0 and core_done in bit 1, with all other bits zero. A write to status completes without error and changes nothing.
- R5: Interrupt enable is read/write. Bit i enables source i, and bits at N_IRQ and above read zero.
- R6: Pending bit i is set by a pulse on irq_event[i], whatever the enable. Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged. If a pulse and a clear of the same bit fall in the same cycle, the bit ends up set.
- R7: The identification register reads ID_VALUE. A write to it completes without error and changes nothing.
- R8: An access whose offset is not word-aligned, or does not map to a register, raises pslverr in the access phase and returns prdata zero. If it is a write, it changes no register.
- R9: Byte lane k of a write to control, enable or pending takes effect only if pstrb[k] is 1. With pstrb[0]=0, none of these three registers changes.
- R10: irq is the OR over all sources of (pending AND enable). It is registered, so it follows a change of pending or enable one clock later.
- R11: pready is always 1. pslverr is never high outside an access phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 for a write, 0 for a read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| pstrb | input | 4 | Write byte lane strobes |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Transfer ready, always 1 |
| pslverr | output | 1 | Error response for an unmapped or misaligned access |
| core_busy | input | 1 | Core busy flag |
| core_done | input | 1 | Core done flag |
| irq_event | input | N_IRQ | One-cycle event pulses, one per source |
| ctrl_enable | output | 1 | Control enable bit |
| ctrl_mode | output | 2 | Control mode field |
| irq | output | 1 | Combined, masked interrupt |

## Verification
A decode fault shows up on the very next read of the affected offset. Either the wrong register's data comes back or the pslverr response is wrong, which is why every byte address of the window, and one address below it, is read against values computed from the offset. A wrong pending or mask bit shows up on irq exactly one clock after the event or write that caused it. For this reason all 256 combinations of enable and pending are swept, and irq is sampled both before and after that clock. A write that lands where it should not, or that ignores a strobe, leaves a register changed, and the next read-back of that register exposes it.

// File: rtl/csr_periph_pkg.sv
package csr_periph_pkg;
    localparam int NUM_REGS  = 5;
    localparam int REG_CTRL  = 0;
    localparam int REG_STAT  = 1;
    localparam int REG_IEN   = 2;
    localparam int REG_IPEND = 3;
    localparam int REG_IDENT = 4;
    localparam int WORD_BYTES = 4;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_ACCESS = 2'd2
    } bus_phase_e;
endpackage

// File: rtl/csr_addr_decode.sv
module csr_addr_decode
    import csr_periph_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter logic [31:0] BASE_ADDR = 32'h0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr,
    output logic [NUM_REGS-1:0] sel,
    output logic                err
);
    localparam int SPAN = NUM_REGS * WORD_BYTES;

    logic [ADDR_W-1:0] rel;
    logic              aligned;

    assign rel     = addr - BASE_ADDR[ADDR_W-1:0];
    assign aligned = (rel[1:0] == 2'b00);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
        assign sel[g] = aligned && (rel == ADDR_W'(g * WORD_BYTES));
    end

    assign err = !aligned || (rel >= ADDR_W'(SPAN));

    assert_sel_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));
    assert_err_nosel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (sel == '0));
endmodule

// File: rtl/csr_irq_unit.sv
module csr_irq_unit #(
    parameter int N_IRQ = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IRQ-1:0] evt,
    input  logic [N_IRQ-1:0] clr_mask,
    input  logic [N_IRQ-1:0] en_mask,
    output logic [N_IRQ-1:0] pend,
    output logic             irq
);
    logic [N_IRQ-1:0] pend_q;
    logic             irq_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            pend_q <= (pend_q & ~clr_mask) | evt;
            irq_q  <= |(pend_q & en_mask);
        end
    end

    assign pend = pend_q;
    assign irq  = irq_q;

    assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((pend & $past(evt)) == $past(evt)));
    assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_mask & ~evt) != '0) |=> ((pend & $past(clr_mask & ~evt)) == '0));
endmodule

// File: rtl/csr_periph_regs.sv
module csr_periph_regs
    import csr_periph_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter logic [31:0] BASE_ADDR = 32'h0,
    parameter int          N_IRQ     = 4,
    parameter logic [31:0] ID_VALUE  = 32'h0A51_0102
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    input  logic [3:0]        pstrb,
    output logic [31:0]       prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic              core_busy,
    input  logic              core_done,
    input  logic [N_IRQ-1:0]  irq_event,
    output logic              ctrl_enable,
    output logic [1:0]        ctrl_mode,
    output logic              irq
);
    localparam int CTRL_W = 3;

    bus_phase_e        phase_q, phase_d;
    logic              in_access, commit;
    logic [NUM_REGS-1:0] sel;
    logic              dec_err;
    logic [31:0]       wmask;
    logic [CTRL_W-1:0] ctrl_q;
    logic [N_IRQ-1:0]  ien_q, pend, clr_mask;
    logic [31:0]       rd_mux;
    logic              unused_wdata;

    assign unused_wdata = ^pwdata;

    // Bus phase tracker: registered state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    always_comb begin
        unique case ({psel, penable})
            2'b10:   phase_d = PH_SETUP;
            2'b11:   phase_d = PH_ACCESS;
            default: phase_d = PH_IDLE;
        endcase
    end

    // Phase-derived outputs
    always_comb begin
        in_access = 1'b0;
        commit    = 1'b0;
        unique case (phase_q)
            PH_SETUP: begin
                in_access = psel && penable;
                commit    = psel && penable && pwrite;
            end
            PH_IDLE, PH_ACCESS: begin
                in_access = 1'b0;
                commit    = 1'b0;
            end
            default: begin
                in_access = 1'b0;
                commit    = 1'b0;
            end
        endcase
    end

    csr_addr_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
        .clk(clk), .rst_n(rst_n), .addr(paddr), .sel(sel), .err(dec_err)
    );

    for (genvar b = 0; b < 4; b++) begin : g_lane
        assign wmask[8*b +: 8] = {8{pstrb[b]}};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            ien_q  <= '0;
        end else if (commit && !dec_err) begin
            if (sel[REG_CTRL])
                ctrl_q <= (ctrl_q & ~wmask[CTRL_W-1:0]) | (pwdata[CTRL_W-1:0] & wmask[CTRL_W-1:0]);
            if (sel[REG_IEN])
                ien_q <= (ien_q & ~wmask[N_IRQ-1:0]) | (pwdata[N_IRQ-1:0] & wmask[N_IRQ-1:0]);
        end
    end

    assign clr_mask = (commit && !dec_err && sel[REG_IPEND])
                    ? (pwdata[N_IRQ-1:0] & wmask[N_IRQ-1:0]) : '0;

    csr_irq_unit #(.N_IRQ(N_IRQ)) u_irq (
        .clk(clk), .rst_n(rst_n), .evt(irq_event), .clr_mask(clr_mask),
        .en_mask(ien_q), .pend(pend), .irq(irq)
    );

    always_comb begin
        rd_mux = '0;
        unique case (1'b1)
            sel[REG_CTRL]:  rd_mux = 32'(ctrl_q);
            sel[REG_STAT]:  rd_mux = {30'b0, core_done, core_busy};
            sel[REG_IEN]:   rd_mux = 32'(ien_q);
            sel[REG_IPEND]: rd_mux = 32'(pend);
            sel[REG_IDENT]: rd_mux = ID_VALUE;
            default:        rd_mux = '0;
        endcase
    end

    assign prdata      = (in_access && !dec_err) ? rd_mux : 32'h0;
    assign pslverr     = in_access && dec_err;
    assign pready      = 1'b1;
    assign ctrl_enable = ctrl_q[0];
    assign ctrl_mode   = ctrl_q[2:1];

    assert_slverr_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pslverr |-> (prdata == 32'h0));
    assert_err_access_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pslverr |-> (psel && penable && $past(psel && !penable)));
    assert_ctrl_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit && sel[REG_CTRL]) |=> $stable({ctrl_mode, ctrl_enable}));
    assert_ien_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit && sel[REG_IEN]) |=> $stable(ien_q));
endmodule

// File: tb/csr_periph_regs_tb.sv
module csr_periph_regs_tb;
    localparam logic [31:0] BASE = 32'h0000_4000;
    localparam logic [31:0] IDV  = 32'h0A51_0102;
    localparam int          NI   = 4;

    logic clk = 0, rst_n = 0;
    logic psel = 0, penable = 0, pwrite = 0;
    logic [31:0] paddr = 0, pwdata = 0;
    logic [3:0]  pstrb = 0;
    logic [31:0] prdata;
    logic pready, pslverr;
    logic core_busy = 0, core_done = 0;
    logic [NI-1:0] irq_event = 0;
    logic ctrl_enable, irq;
    logic [1:0] ctrl_mode;

    int checks = 0, errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    csr_periph_regs #(.ADDR_W(32), .BASE_ADDR(BASE), .N_IRQ(NI), .ID_VALUE(IDV)) u_dut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .pstrb(pstrb), .prdata(prdata), .pready(pready),
        .pslverr(pslverr), .core_busy(core_busy), .core_done(core_done),
        .irq_event(irq_event), .ctrl_enable(ctrl_enable), .ctrl_mode(ctrl_mode), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    logic setup_err;

    task automatic xfer(input logic wr, input logic [31:0] off, input logic [31:0] d,
                        input logic [3:0] s, input logic [NI-1:0] ev,
                        output logic [31:0] rd, output logic er);
        @(negedge clk);
        psel = 1; penable = 0; pwrite = wr; paddr = BASE + off; pwdata = d; pstrb = s;
        #1 setup_err = pslverr;
        @(negedge clk);
        penable = 1; irq_event = ev;
        #1 rd = prdata; er = pslverr;
        @(negedge clk);
        psel = 0; penable = 0; irq_event = '0;
    endtask

    task automatic wr(input logic [31:0] off, input logic [31:0] d, input logic [3:0] s);
        logic [31:0] r; logic e;
        xfer(1'b1, off, d, s, '0, r, e);
    endtask

    task automatic rd(input logic [31:0] off, output logic [31:0] r, output logic e);
        xfer(1'b0, off, 32'h0, 4'h0, '0, r, e);
    endtask

    task automatic pulse(input logic [NI-1:0] v);
        @(negedge clk); irq_event = v;
        @(negedge clk); irq_event = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] r; logic e;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R2 reset state
        rd(32'h00, r, e); chk("R2 ctrl", r, 0);
        rd(32'h08, r, e); chk("R2 ien", r, 0);
        rd(32'h0C, r, e); chk("R2 pend", r, 0);
        chk("R2 irq", {31'b0, irq}, 0);
        chk("R11 pready", {31'b0, pready}, 1);

        // R3 control sweep
        for (int v = 0; v < 8; v++) begin
            wr(32'h00, 32'hFFFF_FFF8 | v, 4'hF);
            rd(32'h00, r, e);
            chk("R3 ctrl rd", r, v);
            chk("R3 ctrl pins", {29'b0, ctrl_mode, ctrl_enable}, v);
        end

        // R9 strobes on control
        wr(32'h00, 32'h0, 4'hF);
        wr(32'h00, 32'h7, 4'b1110); rd(32'h00, r, e); chk("R9 ctrl no lane0", r, 0);
        wr(32'h00, 32'h7, 4'b0001); rd(32'h00, r, e); chk("R9 ctrl lane0", r, 7);

        // R5 enable
        wr(32'h08, 32'hFFFF_FFFF, 4'hF); rd(32'h08, r, e); chk("R5 ien width", r, 32'hF);
        wr(32'h08, 32'h0, 4'b1110);      rd(32'h08, r, e); chk("R9 ien no lane0", r, 32'hF);

        // R4 status sweep and write ignored
        for (int v = 0; v < 4; v++) begin
            core_busy = v[0]; core_done = v[1];
            wr(32'h04, 32'hFFFF_FFFF, 4'hF);
            rd(32'h04, r, e);
            chk("R4 status", r, v);
            chk("R4 no err", {31'b0, e}, 0);
        end
        rd(32'h00, r, e); chk("R4 ctrl untouched", r, 7);

        // R7 identification
        wr(32'h10, 32'h0, 4'hF);
        rd(32'h10, r, e); chk("R7 id", r, IDV); chk("R7 no err", {31'b0, e}, 0);

        // R1/R8 read sweep: CTRL=5, IEN=A, pend=0, busy=1 done=0
        core_busy = 1; core_done = 0;
        wr(32'h00, 32'h5, 4'hF);
        wr(32'h08, 32'hA, 4'hF);
        wr(32'h0C, 32'hF, 4'hF);
        for (int a = -4; a < 32; a++) begin
            logic [31:0] off, expd; logic experr;
            off = 32'(a);
            experr = (a < 0) || (a >= 20) || (a % 4 != 0);
            case (a)
                0:  expd = 32'h5;
                4:  expd = 32'h1;
                8:  expd = 32'hA;
                12: expd = 32'h0;
                16: expd = IDV;
                default: expd = 32'h0;
            endcase
            rd(off, r, e);
            chk("R1 rd data", r, expd);
            chk("R8 err", {31'b0, e}, {31'b0, experr});
            if (experr) chk("R11 no err in setup", {31'b0, setup_err}, 0);
        end

        // R8 writes to error addresses change nothing
        pulse(4'hF);
        for (int a = -4; a < 32; a++) begin
            if ((a < 0) || (a >= 20) || (a % 4 != 0)) wr(32'(a), 32'hFFFF_FFFF, 4'hF);
        end
        wr(32'h14, 32'h0, 4'hF);
        rd(32'h00, r, e); chk("R8 ctrl kept", r, 5);
        rd(32'h08, r, e); chk("R8 ien kept", r, 32'hA);
        rd(32'h0C, r, e); chk("R8 pend kept", r, 32'hF);

        // R9 W1C needs lane 0
        wr(32'h0C, 32'hF, 4'b1110); rd(32'h0C, r, e); chk("R9 w1c no lane0", r, 32'hF);
        // R6 write 0 no effect, partial clear
        wr(32'h0C, 32'h0, 4'hF); rd(32'h0C, r, e); chk("R6 w0 keep", r, 32'hF);
        wr(32'h0C, 32'h5, 4'hF); rd(32'h0C, r, e); chk("R6 w1c", r, 32'hA);
        // R6 set wins over clear
        wr(32'h0C, 32'hF, 4'hF);
        xfer(1'b1, 32'h0C, 32'h3, 4'hF, 4'h1, r, e);
        rd(32'h0C, r, e); chk("R6 set wins", r, 32'h1);

        // R6/R10 sweep of enable x pending
        for (int en = 0; en < 16; en++) begin
            wr(32'h08, 32'(en), 4'hF);
            for (int p = 0; p < 16; p++) begin
                logic expirq;
                wr(32'h0C, 32'hF, 4'hF);
                @(negedge clk);
                chk("R10 cleared", {31'b0, irq}, 0);
                irq_event = 4'(p);
                @(negedge clk); irq_event = '0;
                #1 chk("R10 lag", {31'b0, irq}, 0);
                expirq = ((en & p) != 0);
                @(negedge clk);
                #1 chk("R10 irq", {31'b0, irq}, {31'b0, expirq});
                rd(32'h0C, r, e); chk("R6 pend set", r, 32'(p));
            end
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule